// File: doc/BRIEF.md
# I/O Data-Port Cycle Claim and Ready Handshake

This block watches a 486-style local bus and decides, one address strobe at a time, whether the current cycle is aimed at one of the IDE data ports. An accepted cycle must be an I/O cycle to the primary or secondary data port with byte lane 0 enabled. The block then claims it by pulling an active-low device-claim output and issues a one-cycle start request to the transfer engine. The request carries the width and the direction of the transfer.

While the cycle is owned, the block enables the shared ready line and drives it high. The transfer engine reports completion with a single pulse. The ready line then goes low for one clock, high for one more clock, and is released to high impedance along with the claim. If no completion arrives within a programmable number of clocks, the block runs the same closing sequence by itself and raises a sticky error flag.

One input pin has two meanings, chosen by a mode input. In legacy mode it is the data/code status, and a low level marks interrupt-acknowledge or halt cycles, which are never claimed. In advanced mode it is the drive's flow-control signal and plays no part in the decode.

Top module: `lbus_claim`

## Requirements
- R1: While reset is low at a clock edge, the block returns to idle after that edge: claim_n=1, rdy_oe=0, start_req=0 and timeout_err=0.
- R2: When ads_n=0 at an edge with mio=0, be0_n=0 and io_addr equal to byte address 1F0h or 170h (bits 15:2), claim_n goes low and start_req is 1 for exactly the following cycle.
- R3: No claim and no start follow a strobe with mio=1, a strobe to any other dword address (e.g. 1F4h, 3F4h), or a strobe with be0_n=1.
- R4: With adv_mode=0, a strobe with iordy_dc=0 is not claimed. With adv_mode=1, iordy_dc has no effect on the decode.
- R5: At acceptance, xfer_wide is set to 1 when be2_n=0 and to 0 otherwise, and xfer_wr takes the value of wr. Both hold through the cycle.
- R6: From the claim until the completion pulse is sampled, rdy_oe=1 and rdy_out=1. After the edge that samples xfer_done=1, rdy_out=0 for one cycle, then rdy_out=1 for one cycle, and then rdy_oe=0 and claim_n=1.
- R7: rdy_oe is 1 only while the block holds a claim, and it is first enabled only after a strobe.
- R8: If xfer_done is not seen during TMO_CYC consecutive waiting cycles, the low ready phase starts on the following cycle and timeout_err becomes 1 at the same time. The flag stays 1 until the next accepted cycle clears it.
- R9: Strobes that arrive while a claimed cycle is in progress are ignored: no start request and no new claim after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_mode | input | 1 | 1: advanced mode (flow-control pin), 0: legacy mode (data/code status) |
| ads_n | input | 1 | Address strobe, active low |
| mio | input | 1 | 1 memory cycle, 0 I/O cycle |
| wr | input | 1 | 1 write, 0 read |
| iordy_dc | input | 1 | Shared pin: data/code status in legacy mode, flow control in advanced mode |
| be0_n | input | 1 | Byte enable 0, active low |
| be2_n | input | 1 | Byte enable 2, active low; low marks a 32-bit transfer |
| io_addr | input | ADDR_W-2 | Dword address, bits ADDR_W-1:2 |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| claim_n | output | 1 | Local device claim, active low |
| rdy_out | output | 1 | Value for the shared ready line |
| rdy_oe | output | 1 | Output enable of the ready line |
| start_req | output | 1 | One-cycle start request to the transfer engine |
| xfer_wide | output | 1 | 1 for a 32-bit transfer |
| xfer_wr | output | 1 | Direction of the accepted cycle |
| timeout_err | output | 1 | Sticky flag: the last cycle ended by timeout |

## Verification
The assertions check the protocol shape on every cycle: the low ready phase lasts exactly one clock and is followed by one high clock and then release. They also check that the enable rises only with the line high, that a start request lasts one cycle and accepts only I/O strobes, that no wait runs longer than the timeout, and that the error flag rises only inside a low phase. The address and status decode needs the bench's scenarios, because only those scenarios prove that specific addresses, byte enables, modes and busy-time strobes are refused or accepted. The same holds for the captured width and direction flags and for the exact cycle at which the timeout fires.

// File: rtl/lbus_pkg.sv
// Shared types for the local-bus claim block.
// Assumes: one claimed cycle in flight at a time.
package lbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOW  = 2'd2,
        ST_TAIL = 2'd3
    } hs_state_t;
endpackage

// File: rtl/lbus_decode.sv
// Address and status decode for one strobe.
// Raises hit when the strobe is an I/O cycle to any configured data port
// with byte lane 0 enabled. In legacy mode the shared pin must also mark
// a data cycle. Purely combinational; the caller samples it at the edge.
module lbus_decode #(
    parameter int ADDR_W    = 16,
    parameter int NUM_PORTS = 2,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_BASES = {16'h0170, 16'h01F0}
) (
    input  logic              ads_n,
    input  logic              mio,
    input  logic              dc_pin,
    input  logic              adv_mode,
    input  logic              be0_n,
    input  logic [ADDR_W-1:2] io_addr,
    output logic              hit
);
    logic [NUM_PORTS-1:0] match;
    logic                 io_cycle;

    // One comparator per configured data port
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
        assign match[gi] = (io_addr == PORT_BASES[gi*ADDR_W+2 +: ADDR_W-2]);
    end

    // Qualify the cycle type; the shared pin only matters in legacy mode
    always_comb begin
        io_cycle = !mio && (adv_mode || dc_pin);
        hit      = !ads_n && io_cycle && !be0_n && (|match);
    end
endmodule

// File: rtl/lbus_watchdog.sv
// Wait-phase watchdog.
// Counts cycles while run is high and reports expiry on the
// TMO_CYC-th consecutive run cycle. clear returns the count to zero.
// Assumes TMO_CYC >= 2.
module lbus_watchdog #(
    parameter int TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    // Count waiting cycles, held at the last value until cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry is flagged during the last allowed waiting cycle
    always_comb begin
        expired = run && (cnt == LAST);
    end
endmodule

// File: rtl/lbus_handshake.sv
// Claim and ready-line sequencer.
// IDLE accepts a hit and enters WAIT, driving ready high. A completion
// pulse or watchdog expiry moves to LOW for one cycle, then to TAIL
// (high) for one cycle, then back to IDLE with the line released.
// Strobes seen outside IDLE are ignored.
module lbus_handshake
    import lbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic done,
    input  logic expired,
    input  logic wide_in,
    input  logic wr_in,
    output logic claim_n,
    output logic rdy_out,
    output logic rdy_oe,
    output logic start_req,
    output logic xfer_wide,
    output logic xfer_wr,
    output logic timeout_err,
    output logic wd_clear,
    output logic wd_run
);
    hs_state_t state;

    // State sequencing, start pulse and captured flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            start_req   <= 1'b0;
            xfer_wide   <= 1'b0;
            xfer_wr     <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            start_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (hit) begin
                        state       <= ST_WAIT;
                        start_req   <= 1'b1;
                        xfer_wide   <= wide_in;
                        xfer_wr     <= wr_in;
                        timeout_err <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (done) begin
                        state <= ST_LOW;
                    end else if (expired) begin
                        state       <= ST_LOW;
                        timeout_err <= 1'b1;
                    end
                end
                ST_LOW:  state <= ST_TAIL;
                ST_TAIL: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pin values follow the registered state
    always_comb begin
        claim_n  = (state == ST_IDLE);
        rdy_oe   = (state != ST_IDLE);
        rdy_out  = (state != ST_LOW);
        wd_run   = (state == ST_WAIT);
        wd_clear = (state != ST_WAIT);
    end
endmodule

// File: rtl/lbus_claim.sv
// Local-bus target claim for the IDE data ports.
// Decodes each strobe, claims matching I/O cycles, requests a transfer
// and runs the tri-state ready handshake, with a timeout fallback.
// Assumes a synchronous active-low reset and one cycle in flight.
module lbus_claim #(
    parameter int ADDR_W    = 16,
    parameter int NUM_PORTS = 2,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_BASES = {16'h0170, 16'h01F0},
    parameter int TMO_CYC   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_mode,
    input  logic              ads_n,
    input  logic              mio,
    input  logic              wr,
    input  logic              iordy_dc,
    input  logic              be0_n,
    input  logic              be2_n,
    input  logic [ADDR_W-1:2] io_addr,
    input  logic              xfer_done,
    output logic              claim_n,
    output logic              rdy_out,
    output logic              rdy_oe,
    output logic              start_req,
    output logic              xfer_wide,
    output logic              xfer_wr,
    output logic              timeout_err
);
    logic hit;
    logic expired;
    logic wd_clear;
    logic wd_run;

    lbus_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS),
        .PORT_BASES(PORT_BASES)
    ) u_decode (
        .ads_n   (ads_n),
        .mio     (mio),
        .dc_pin  (iordy_dc),
        .adv_mode(adv_mode),
        .be0_n   (be0_n),
        .io_addr (io_addr),
        .hit     (hit)
    );

    lbus_watchdog #(
        .TMO_CYC(TMO_CYC)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (wd_clear),
        .run    (wd_run),
        .expired(expired)
    );

    lbus_handshake u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .done       (xfer_done),
        .expired    (expired),
        .wide_in    (!be2_n),
        .wr_in      (wr),
        .claim_n    (claim_n),
        .rdy_out    (rdy_out),
        .rdy_oe     (rdy_oe),
        .start_req  (start_req),
        .xfer_wide  (xfer_wide),
        .xfer_wr    (xfer_wr),
        .timeout_err(timeout_err),
        .wd_clear   (wd_clear),
        .wd_run     (wd_run)
    );
endmodule

// File: rtl/lbus_claim_chk.sv
// Protocol checker for lbus_claim, attached with bind.
// Watches only the top-level ports.
module lbus_claim_chk #(
    parameter int TMO_CYC = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic ads_n,
    input logic mio,
    input logic claim_n,
    input logic rdy_out,
    input logic rdy_oe,
    input logic start_req,
    input logic timeout_err
);
    localparam int RW = $clog2(TMO_CYC + 2) + 1;

    logic [RW-1:0] high_run;

    // Length of the current stretch of driven-high ready cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_run <= '0;
        end else if (rdy_oe && rdy_out) begin
            high_run <= high_run + 1'b1;
        end else begin
            high_run <= '0;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (claim_n && !rdy_oe && !start_req && !timeout_err));

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req);

    // R2
    start_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> !claim_n);

    // R3
    start_io_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_req) |-> $past(!ads_n && !mio));

    // R6
    low_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe && !rdy_out) |=> (rdy_oe && rdy_out));

    // R6
    release_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe && $rose(rdy_out)) |=> (!rdy_oe && claim_n));

    // R7
    enable_high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_oe) |-> (rdy_out && $past(!ads_n)));

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_run <= RW'(TMO_CYC));

    // R8
    err_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (rdy_oe && !rdy_out));
endmodule

bind lbus_claim lbus_claim_chk #(.TMO_CYC(TMO_CYC)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ads_n      (ads_n),
    .mio        (mio),
    .claim_n    (claim_n),
    .rdy_out    (rdy_out),
    .rdy_oe     (rdy_oe),
    .start_req  (start_req),
    .timeout_err(timeout_err)
);

// File: tb/test_lbus_claim.sv
`timescale 1ns/1ps
module test_lbus_claim;
    localparam int TMO = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_mode = 1'b1;
    logic        ads_n = 1'b1;
    logic        mio = 1'b1;
    logic        wr = 1'b0;
    logic        iordy_dc = 1'b1;
    logic        be0_n = 1'b1;
    logic        be2_n = 1'b1;
    logic [15:2] io_addr = '0;
    logic        xfer_done = 1'b0;
    logic        claim_n, rdy_out, rdy_oe, start_req, xfer_wide, xfer_wr, timeout_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lbus_claim #(.TMO_CYC(TMO)) i_lbus_claim (
        .clk(clk), .rst_n(rst_n), .adv_mode(adv_mode), .ads_n(ads_n), .mio(mio),
        .wr(wr), .iordy_dc(iordy_dc), .be0_n(be0_n), .be2_n(be2_n),
        .io_addr(io_addr), .xfer_done(xfer_done), .claim_n(claim_n),
        .rdy_out(rdy_out), .rdy_oe(rdy_oe), .start_req(start_req),
        .xfer_wide(xfer_wide), .xfer_wr(xfer_wr), .timeout_err(timeout_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present a strobe at the current (falling) edge
    task automatic strobe(input logic [15:0] a, input logic m, input logic w,
                          input logic d, input logic b0, input logic b2);
        ads_n = 1'b0; mio = m; wr = w; iordy_dc = d; be0_n = b0; be2_n = b2;
        io_addr = a[15:2];
    endtask

    task automatic bus_idle();
        ads_n = 1'b1; mio = 1'b1; be0_n = 1'b1; be2_n = 1'b1;
    endtask

    // Expect a claim that was accepted at the previous edge
    task automatic expect_accept(input logic wide, input logic w);
        chk("R2", "claim_n", claim_n, 0);
        chk("R2", "start_req", start_req, 1);
        chk("R5", "xfer_wide", xfer_wide, wide);
        chk("R5", "xfer_wr", xfer_wr, w);
        chk("R6", "rdy_oe", rdy_oe, 1);
        chk("R6", "rdy_out", rdy_out, 1);
        chk("R8", "err cleared", timeout_err, 0);
    endtask

    // Pulse completion now and check the closing sequence
    task automatic close_cycle();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R6", "low phase out", rdy_out, 0);
        chk("R6", "low phase oe", rdy_oe, 1);
        @(negedge clk);
        chk("R6", "tail out", rdy_out, 1);
        chk("R6", "tail oe", rdy_oe, 1);
        @(negedge clk);
        chk("R6", "released oe", rdy_oe, 0);
        chk("R6", "released claim", claim_n, 1);
    endtask

    // Strobe that must be refused
    task automatic expect_refused(input string req, input logic [15:0] a, input logic m,
                                  input logic d, input logic b0);
        @(negedge clk);
        strobe(a, m, 1'b0, d, b0, 1'b0);
        @(negedge clk);
        bus_idle();
        chk(req, "claim_n refused", claim_n, 1);
        chk(req, "start refused", start_req, 0);
        chk("R7", "oe refused", rdy_oe, 0);
        @(negedge clk);
        chk(req, "claim_n later", claim_n, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "claim_n", claim_n, 1);
        chk("R1", "rdy_oe", rdy_oe, 0);
        chk("R1", "start_req", start_req, 0);
        chk("R1", "timeout_err", timeout_err, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_primary_read32();
        @(negedge clk);
        strobe(16'h01F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        bus_idle();
        expect_accept(1'b1, 1'b0);
        @(negedge clk);
        chk("R2", "start ends", start_req, 0);
        chk("R7", "claim held", claim_n, 0);
        @(negedge clk);
        chk("R6", "waiting high", rdy_out, 1);
        chk("R6", "waiting oe", rdy_oe, 1);
        close_cycle();
    endtask

    task automatic t_secondary_write16();
        @(negedge clk);
        strobe(16'h0170, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        bus_idle();
        expect_accept(1'b0, 1'b1);
        close_cycle();
    endtask

    task automatic t_refused();
        expect_refused("R3", 16'h01F0, 1'b1, 1'b1, 1'b0);
        expect_refused("R3", 16'h01F4, 1'b0, 1'b1, 1'b0);
        expect_refused("R3", 16'h03F4, 1'b0, 1'b1, 1'b0);
        expect_refused("R3", 16'h01F0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_modes();
        adv_mode = 1'b0;
        expect_refused("R4", 16'h01F0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        strobe(16'h01F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        bus_idle();
        chk("R4", "legacy data claim", claim_n, 0);
        close_cycle();
        adv_mode = 1'b1;
        @(negedge clk);
        strobe(16'h0170, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        bus_idle();
        chk("R4", "advanced ignores pin", claim_n, 0);
        chk("R4", "advanced start", start_req, 1);
        close_cycle();
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        strobe(16'h01F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        expect_accept(1'b1, 1'b0);
        strobe(16'h0170, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9", "no second start", start_req, 0);
        chk("R9", "flags kept", xfer_wr, 0);
        bus_idle();
        close_cycle();
        @(negedge clk);
        chk("R9", "no claim after release", claim_n, 1);
        chk("R9", "no start after release", start_req, 0);
    endtask

    task automatic t_timeout();
        @(negedge clk);
        strobe(16'h01F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        bus_idle();
        expect_accept(1'b1, 1'b0);
        repeat (TMO - 1) @(negedge clk);
        chk("R8", "last wait cycle high", rdy_out, 1);
        chk("R8", "no error yet", timeout_err, 0);
        @(negedge clk);
        chk("R8", "timeout low phase", rdy_out, 0);
        chk("R8", "error set", timeout_err, 1);
        @(negedge clk);
        chk("R8", "timeout tail", rdy_out, 1);
        @(negedge clk);
        chk("R8", "timeout release", rdy_oe, 0);
        chk("R8", "error sticky", timeout_err, 1);
        @(negedge clk);
        strobe(16'h0170, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        bus_idle();
        chk("R8", "error cleared on accept", timeout_err, 0);
        close_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_primary_read32();
        t_secondary_write16();
        t_refused();
        t_modes();
        t_busy_ignore();
        t_timeout();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule